// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside instruction fetch and guesses, in the same cycle as the fetch address is presented, whether the instruction at that address is a taken branch and where it goes. A direct-mapped table of direction states is selected by low-order word-address bits of the fetch PC. No tag is kept, so branches whose addresses differ only above the index bits share one entry. That costs accuracy, never correctness. A parallel target store holds the last taken destination and a valid flag for each index. A selector then picks the predicted target or the sequential address PC+4 as the next fetch address.

When a branch resolves in decode, the pipeline returns the outcome, the actual target, and the prediction and target that were carried along with the instruction. The block trains the entry from that return. In the same cycle it raises a mispredict flag and offers the corrected fetch address, so the external flush logic can discard the wrong-path instruction. A parameter chooses the direction state: a two-bit saturating counter by default, or a single last-outcome bit for comparison.

Top module: `brp_predictor`

## Requirements
- R1: After reset every entry predicts not taken and has no valid target, so `pred_taken` is 0 and `next_pc` is `fetch_pc`+4 for any address until a taken outcome has been written.
- R2: The entry is selected by `fetch_pc[IDX_W+1:2]` (and `upd_pc[IDX_W+1:2]` on update) with no tag check, so two addresses that differ only above bit IDX_W+1 read the same prediction and target, and addresses with different index bits do not interfere.
- R3: In two-bit mode each entry is a counter coded 00/01 (predict not taken) and 10/11 (predict taken). It resets to 01. A taken outcome moves it one step toward 11 and a not-taken outcome one step toward 00, saturating at both ends.
- R4: In two-bit mode a loop branch that starts in a trained-taken state, is taken nine times and then not taken, mispredicts only on the exit, and the next entry into the loop is still predicted taken.
- R5: In one-bit mode (`TWO_BIT`=0) each entry resets to not taken, and a single wrong outcome inverts the stored bit.
- R6: A taken update writes `upd_target` into the target store and marks it valid. A not-taken update leaves the stored target unchanged.
- R7: `pred_taken` is 1 only when the direction state predicts taken and the target entry is valid. `next_pc` equals `pred_target` when `pred_taken` is 1 and `fetch_pc`+4 otherwise, in the same cycle as `fetch_pc`.
- R8: `mispredict` is raised combinationally in the cycle `upd_valid` is high when the outcome differs from `upd_pred_taken`, or when both are taken and `upd_pred_target` differs from `upd_target`. It is never high without `upd_valid`.
- R9: `correct_pc` equals `upd_target` for a taken outcome and `upd_pc`+4 for a not-taken outcome.
- R10: When a lookup and an update select the same entry in one cycle, the lookup returns the state held before the update, and the new state appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Current fetch address |
| pred_taken | output | 1 | Fetch-stage taken prediction |
| pred_target | output | PC_W | Cached target for the fetch index |
| next_pc | output | PC_W | Selected next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual taken destination |
| upd_pred_taken | input | 1 | Prediction carried with the instruction |
| upd_pred_target | input | PC_W | Target carried with the instruction |
| mispredict | output | 1 | Prediction was wrong; flush requested |
| correct_pc | output | PC_W | Fetch restart address |

## Verification
Prediction outputs (`pred_taken`, `pred_target`, `next_pc`) and resolve outputs (`mispredict`, `correct_pc`) are combinational, so they are due in the same cycle their inputs change. Table state written by an update becomes visible one clock edge later. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. Each check on trained state is therefore made in the cycle after the edge that wrote it. The same-cycle collision case samples both before and after that single edge.

// File: rtl/brp_pkg.sv
package brp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_e;

   // saturating one-step move toward the observed outcome
   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      nxt = cur;
      if (taken && cur != CTR_STRONG_T)
         nxt = cur + 2'd1;
      else if (!taken && cur != CTR_STRONG_NT)
         nxt = cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input logic [1:0] cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/brp_counter_table.sv
module brp_counter_table
   import brp_pkg::*;
#(
   parameter int IDX_W   = 10,
   parameter bit TWO_BIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int DEPTH = 1 << IDX_W;

   generate
      if (TWO_BIT) begin : g_two_bit
         logic [1:0] ctr_q [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++)
                  ctr_q[i] <= CTR_WEAK_NT;
            end else if (wr_en) begin
               ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
            end
         end

         assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);
      end else begin : g_one_bit
         logic [DEPTH-1:0] last_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_q <= '0;
            end else if (wr_en && (last_q[wr_idx] != wr_taken)) begin
               last_q[wr_idx] <= ~last_q[wr_idx];
            end
         end

         assign rd_taken = last_q[rd_idx];
      end
   endgenerate

endmodule

// File: rtl/brp_target_store.sv
module brp_target_store #(
   parameter int IDX_W = 10,
   parameter int PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_target,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PC_W-1:0]  wr_target
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] valid_q;
   logic [PC_W-1:0]  dest_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n)
         valid_q <= '0;
      else if (wr_en)
         valid_q[wr_idx] <= 1'b1;
   end

   // payload needs no reset: it is gated by valid_q
   always_ff @(posedge clk) begin
      if (wr_en)
         dest_q[wr_idx] <= wr_target;
   end

   assign rd_hit    = valid_q[rd_idx];
   assign rd_target = dest_q[rd_idx];

endmodule

// File: rtl/brp_next_pc.sv
module brp_next_pc #(
   parameter int PC_W = 32
) (
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            dir_taken,
   input  logic            tgt_hit,
   input  logic [PC_W-1:0] tgt_addr,
   output logic            sel_taken,
   output logic [PC_W-1:0] sel_pc
);

   localparam logic [PC_W-1:0] WORD_STEP = PC_W'(4);

   always_comb begin
      sel_taken = dir_taken & tgt_hit;
      sel_pc    = sel_taken ? tgt_addr : fetch_pc + WORD_STEP;
   end

endmodule

// File: rtl/brp_predictor.sv
module brp_predictor #(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 10,
   parameter bit TWO_BIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_target,
   output logic [PC_W-1:0] next_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_pred_taken,
   input  logic [PC_W-1:0] upd_pred_target,
   output logic            mispredict,
   output logic [PC_W-1:0] correct_pc
);

   localparam int IDX_LO = 2;
   localparam int IDX_HI = IDX_W + IDX_LO - 1;
   localparam logic [PC_W-1:0] WORD_STEP = PC_W'(4);

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("brp_predictor: IDX_W must lie in 1..16");
   end
   if (PC_W < IDX_HI + 2) begin : g_bad_pc
      $error("brp_predictor: PC_W too narrow for the index field");
   end

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic             dir_taken;
   logic             tgt_hit;
   logic [PC_W-1:0]  tgt_addr;

   assign rd_idx = fetch_pc[IDX_HI:IDX_LO];
   assign wr_idx = upd_pc[IDX_HI:IDX_LO];

   brp_counter_table #(
      .IDX_W   (IDX_W),
      .TWO_BIT (TWO_BIT)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid),
      .wr_idx   (wr_idx),
      .wr_taken (upd_taken)
   );

   brp_target_store #(
      .IDX_W (IDX_W),
      .PC_W  (PC_W)
   ) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .rd_hit    (tgt_hit),
      .rd_target (tgt_addr),
      .wr_en     (upd_valid & upd_taken),
      .wr_idx    (wr_idx),
      .wr_target (upd_target)
   );

   brp_next_pc #(
      .PC_W (PC_W)
   ) u_sel (
      .fetch_pc  (fetch_pc),
      .dir_taken (dir_taken),
      .tgt_hit   (tgt_hit),
      .tgt_addr  (tgt_addr),
      .sel_taken (pred_taken),
      .sel_pc    (next_pc)
   );

   assign pred_target = tgt_addr;

   logic dir_wrong;
   logic dest_wrong;

   always_comb begin
      dir_wrong  = upd_taken != upd_pred_taken;
      dest_wrong = upd_taken & upd_pred_taken & (upd_pred_target != upd_target);
      mispredict = upd_valid & (dir_wrong | dest_wrong);
      correct_pc = upd_taken ? upd_target : upd_pc + WORD_STEP;
   end

endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_target,
   input logic [PC_W-1:0] next_pc,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken,
   input logic [PC_W-1:0] upd_target,
   input logic            mispredict,
   input logic [PC_W-1:0] correct_pc
);

   logic seen_taken_q;
   logic past_ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_taken_q <= 1'b0;
         past_ok_q    <= 1'b0;
      end else begin
         past_ok_q <= 1'b1;
         if (upd_valid && upd_taken)
            seen_taken_q <= 1'b1;
      end
   end

   // R1
   cold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_taken_q |-> !pred_taken);

   // R7
   sel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> next_pc == pred_target);

   // R7
   sel_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> next_pc == fetch_pc + PC_W'(4));

   // R8
   misp_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> upd_valid);

   // R9
   fix_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |-> correct_pc == upd_pc + PC_W'(4));

   // R6
   tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $past(upd_valid && upd_taken)
       && fetch_pc[IDX_W+1:2] == $past(upd_pc[IDX_W+1:2]))
      |-> pred_target == $past(upd_target));

endmodule

bind brp_predictor brp_checker #(
   .PC_W  (PC_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_pc    (fetch_pc),
   .pred_taken  (pred_taken),
   .pred_target (pred_target),
   .next_pc     (next_pc),
   .upd_valid   (upd_valid),
   .upd_pc      (upd_pc),
   .upd_taken   (upd_taken),
   .upd_target  (upd_target),
   .mispredict  (mispredict),
   .correct_pc  (correct_pc)
);

// File: tb/sim_brp_predictor.sv
module sim_brp_predictor;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // two-bit instance
   logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0, upd_pred_target = '0;
   logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_pred_taken = 1'b0;
   logic        pred_taken, mispredict;
   logic [31:0] pred_target, next_pc, correct_pc;

   brp_predictor #(.PC_W(32), .IDX_W(10), .TWO_BIT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
      .pred_target(pred_target), .next_pc(next_pc), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
      .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
      .mispredict(mispredict), .correct_pc(correct_pc));

   // one-bit instance
   logic [31:0] b_fetch_pc = '0, b_upd_pc = '0, b_upd_target = '0;
   logic        b_upd_valid = 1'b0, b_upd_taken = 1'b0, b_upd_pred_taken = 1'b0;
   logic        b_pred_taken, b_mispredict;
   logic [31:0] b_pred_target, b_next_pc, b_correct_pc;

   brp_predictor #(.PC_W(32), .IDX_W(4), .TWO_BIT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(b_fetch_pc), .pred_taken(b_pred_taken),
      .pred_target(b_pred_target), .next_pc(b_next_pc), .upd_valid(b_upd_valid),
      .upd_pc(b_upd_pc), .upd_taken(b_upd_taken), .upd_target(b_upd_target),
      .upd_pred_taken(b_upd_pred_taken), .upd_pred_target(b_upd_target),
      .mispredict(b_mispredict), .correct_pc(b_correct_pc));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   localparam logic [31:0] BR  = 32'h0000_0100;
   localparam logic [31:0] DST = 32'h0000_0400;

   // {outcome, expected prediction before update, expected mispredict}
   localparam int NROWS = 19;
   localparam logic [2:0] VEC [NROWS] = '{
      3'b101,                                  // 01 -> 10
      3'b110,                                  // 10 -> 11, trained
      3'b110, 3'b110, 3'b110, 3'b110,
      3'b110, 3'b110, 3'b110, 3'b110,          // nine taken iterations in all
      3'b011,                                  // loop exit: only miss
      3'b110,                                  // re-entry still taken
      3'b011, 3'b011,                          // 11 -> 10 -> 01
      3'b000, 3'b000,                          // 00, saturated
      3'b101, 3'b101,                          // 00 -> 01 -> 10
      3'b110                                   // 10 -> 11
   };

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      fetch_pc = BR;
      #1;
      chk("R1 pred_taken", {31'd0, pred_taken}, 32'd0);
      chk("R1 next_pc", next_pc, BR + 32'd4);
      chk("R8 idle mispredict", {31'd0, mispredict}, 32'd0);

      // R3 / R4 table walk
      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         fetch_pc        = BR;
         upd_valid       = 1'b1;
         upd_pc          = BR;
         upd_taken       = VEC[i][2];
         upd_target      = DST;
         upd_pred_taken  = VEC[i][1];
         upd_pred_target = DST;
         #1;
         chk($sformatf("R3 R4 row %0d prediction", i), {31'd0, pred_taken}, {31'd0, VEC[i][1]});
         chk($sformatf("R4 row %0d mispredict", i), {31'd0, mispredict}, {31'd0, VEC[i][0]});
      end
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      // R7 selector uses cached target
      chk("R7 pred_taken", {31'd0, pred_taken}, 32'd1);
      chk("R7 next_pc", next_pc, DST);
      // R2 alias above index shares entry, neighbour index does not
      fetch_pc = BR + 32'h0000_1000;
      #1;
      chk("R2 alias pred", {31'd0, pred_taken}, 32'd1);
      chk("R2 alias target", pred_target, DST);
      fetch_pc = BR + 32'd4;
      #1;
      chk("R2 neighbour pred", {31'd0, pred_taken}, 32'd0);

      // R6 two not-taken updates: 11 -> 10 -> 01, target retained
      fetch_pc = BR;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         upd_valid = 1'b1; upd_pc = BR; upd_taken = 1'b0;
         upd_target = 32'h0000_0900; upd_pred_taken = 1'b1;
         #1;
         chk("R9 not-taken correct_pc", correct_pc, BR + 32'd4);
      end
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      chk("R6 not taken after two misses", {31'd0, pred_taken}, 32'd0);
      chk("R6 target kept", pred_target, DST);
      chk("R7 sequential next_pc", next_pc, BR + 32'd4);

      // R8 target mismatch with matching direction
      upd_valid = 1'b1; upd_pc = BR; upd_taken = 1'b1; upd_target = DST;
      upd_pred_taken = 1'b1; upd_pred_target = 32'h0000_0500;
      #1;
      chk("R8 target mismatch", {31'd0, mispredict}, 32'd1);
      chk("R9 taken correct_pc", correct_pc, DST);
      upd_pred_target = DST;
      #1;
      chk("R8 matching target", {31'd0, mispredict}, 32'd0);
      @(negedge clk);
      upd_valid = 1'b0;

      // R10 same-cycle lookup and update on a fresh entry
      @(negedge clk);
      fetch_pc = 32'h0000_0200;
      upd_valid = 1'b1; upd_pc = 32'h0000_0200; upd_taken = 1'b1;
      upd_target = 32'h0000_0800; upd_pred_taken = 1'b0; upd_pred_target = '0;
      #1;
      chk("R10 old value pred", {31'd0, pred_taken}, 32'd0);
      chk("R10 old next_pc", next_pc, 32'h0000_0204);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      chk("R10 new value pred", {31'd0, pred_taken}, 32'd1);
      chk("R10 new next_pc", next_pc, 32'h0000_0800);

      // R5 one-bit mode
      b_fetch_pc = 32'h0000_0010;
      #1;
      chk("R5 reset pred", {31'd0, b_pred_taken}, 32'd0);
      b_upd_valid = 1'b1; b_upd_pc = 32'h0000_0010; b_upd_taken = 1'b1;
      b_upd_target = 32'h0000_0300; b_upd_pred_taken = 1'b0;
      #1;
      chk("R5 miss flagged", {31'd0, b_mispredict}, 32'd1);
      @(negedge clk);
      b_upd_valid = 1'b0;
      #1;
      chk("R5 flipped to taken", {31'd0, b_pred_taken}, 32'd1);
      chk("R5 next_pc", b_next_pc, 32'h0000_0300);
      b_upd_valid = 1'b1; b_upd_taken = 1'b0; b_upd_pred_taken = 1'b1;
      @(negedge clk);
      b_upd_valid = 1'b0;
      #1;
      chk("R5 one miss flips back", {31'd0, b_pred_taken}, 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule